// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every clock cycle, which hardware thread the instruction fetch stage of a multithreaded core should serve. Each thread supplies a status code and two occupancy counts: how many entries it holds in the issue queue and in the load/store queue. A policy input chooses how the winner is picked. The choices are a fixed single-thread mode, a round-robin mode driven by an ordered priority list, or a mode that favours the eligible thread with the largest issue-queue or load/store-queue count. A thread-count input says how many threads are configured. A hold input lets the fetch stage pause selection, for example while a drain is pending.

The grant is combinational from the current inputs, so the fetch stage sees it in the same cycle. The round-robin priority list is the only data state. It is stored as an ordered list of thread IDs: a granted thread leaves its place and moves to the tail, and the threads behind it each move up one place.

A two-state machine watches the configuration. It rests in ST_SERVE. It takes the transition SERVE_TO_ERR into ST_CFG_ERR at a clock edge where single-thread policy is selected while more than one thread is configured. It takes ERR_TO_SERVE back to ST_SERVE at the first edge where that condition is gone. Otherwise each state holds itself (SERVE_HOLD, ERR_HOLD).

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its 3-bit status is 0 (running), 1 (cache access complete) or 2 (idle). Codes 3 to 7 (blocked, squashing, waiting on a cache response, waiting on a cache retry, off) are never granted.
- R2: In round-robin policy (`sel_policy` = 1) with two or more threads configured, the grant goes to the first eligible thread found when the priority list is scanned from head to tail. At the next edge that thread moves to the tail, and the threads that were behind it each move up one place.
- R3: When no thread is eligible, `grant_vld` is 0.
- R4: Reset loads the priority list in ascending thread-ID order (0 at the head) and places the state machine in ST_SERVE, with `cfg_err` at 0.
- R5: Single-thread policy (`sel_policy` = 0) with one thread configured grants thread 0 whenever thread 0 is eligible.
- R6: Single-thread policy with `thr_count` greater than 1 is a configuration error. `grant_vld` is 0 in that same cycle. `cfg_err` reads 1 from the following cycle and stays 1 through the first cycle after the configuration has been corrected.
- R7: With `thr_count` = 1, every policy grants thread 0 if it is eligible, and the round-robin list does not change.
- R8: In issue-queue policy (`sel_policy` = 2), the grant goes to the eligible thread with the largest `iq_occ` count. Ties go to the lower thread ID.
- R9: In load/store-queue policy (`sel_policy` = 3), the same rule is applied to `lsq_occ`. `iq_occ` is ignored.
- R10: The priority list changes only at the end of a cycle that produced a round-robin grant. While `hold` is 1, `grant_vld` is 0 and the list is left unchanged.
- R11: A thread whose ID is not less than `thr_count` is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_policy | input | 2 | 0 single-thread, 1 round-robin, 2 issue-queue count, 3 load/store-queue count |
| thr_count | input | 3 | Number of configured threads (threads 0 to thr_count-1 are active) |
| hold | input | 1 | Suppresses the grant and the list rotation |
| thr_status | input | 12 | Per-thread 3-bit status; thread i occupies bits [3i+2:3i] |
| iq_occ | input | 24 | Per-thread 6-bit issue-queue count; thread i occupies bits [6i+5:6i] |
| lsq_occ | input | 24 | Per-thread 6-bit load/store-queue count, packed the same way as iq_occ |
| grant_vld | output | 1 | A thread is granted this cycle |
| grant_tid | output | 2 | ID of the granted thread |
| cfg_err | output | 1 | Registered configuration-error flag (state ST_CFG_ERR) |

## Verification
A corrupted priority list does not stay hidden. It shows on the first round-robin cycle in which the list is consulted, because the grant then names a thread other than the one the ordering rules predict. A lost or duplicated entry also starves one thread within a few round-robin cycles. A missed or spurious rotation after a hold, an empty cycle or a single-thread cycle shows on the very next round-robin grant. A wrong state-machine state shows on `cfg_err` one cycle after the configuration changes.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [1:0] {
        POL_SINGLE = 2'd0,
        POL_RR     = 2'd1,
        POL_IQ     = 2'd2,
        POL_LSQ    = 2'd3
    } pol_e;

    typedef enum logic [STAT_W-1:0] {
        TS_RUN        = 3'd0,
        TS_DONE       = 3'd1,
        TS_IDLE       = 3'd2,
        TS_BLOCK      = 3'd3,
        TS_SQUASH     = 3'd4,
        TS_WAIT_RESP  = 3'd5,
        TS_WAIT_RETRY = 3'd6,
        TS_OFF        = 3'd7
    } tstat_e;

    typedef enum logic {
        ST_SERVE   = 1'b0,
        ST_CFG_ERR = 1'b1
    } sel_state_e;

endpackage

// File: rtl/fsel_rr_order.sv
`timescale 1ns/1ps
module fsel_rr_order #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTHR-1:0]  elig,
    input  logic             adv,
    output logic             hit,
    output logic [TID_W-1:0] pick_tid
);

    logic [TID_W-1:0]      order_q [NTHR];
    logic [TID_W-1:0]      order_d [NTHR];
    logic [TID_W-1:0]      pos;
    logic [NTHR*TID_W-1:0] order_flat;
    logic [NTHR-1:0]       seen;

    // first eligible entry scanning from head
    always_comb begin
        hit      = 1'b0;
        pos      = '0;
        pick_tid = '0;
        for (int p = 0; p < NTHR; p++) begin
            if (!hit && elig[order_q[p]]) begin
                hit      = 1'b1;
                pos      = TID_W'(p);
                pick_tid = order_q[p];
            end
        end
    end

    // granted entry goes to tail, later entries move up
    for (genvar gp = 0; gp < NTHR; gp++) begin : g_next
        if (gp == NTHR - 1) begin : g_tail
            assign order_d[gp] = pick_tid;
        end else begin : g_body
            assign order_d[gp] = (TID_W'(gp) < pos) ? order_q[gp] : order_q[gp+1];
        end
        assign order_flat[gp*TID_W +: TID_W] = order_q[gp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTHR; i++) order_q[i] <= TID_W'(i);
        end else if (adv && hit) begin
            for (int i = 0; i < NTHR; i++) order_q[i] <= order_d[i];
        end
    end

    always_comb begin
        seen = '0;
        for (int p = 0; p < NTHR; p++) seen[order_q[p]] = 1'b1;
    end

    AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NTHR); // R2

    AST_TAIL_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hit) |=> order_flat[(NTHR-1)*TID_W +: TID_W] == $past(pick_tid)); // R2

    AST_ORDER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && hit) |=> order_flat == $past(order_flat)); // R10

endmodule

// File: rtl/fsel_occ_pick.sv
`timescale 1ns/1ps
module fsel_occ_pick #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2,
    parameter int OCC_W = 6
) (
    input  logic [NTHR-1:0]       elig,
    input  logic [NTHR*OCC_W-1:0] occ_flat,
    output logic                  hit,
    output logic [TID_W-1:0]      pick_tid
);

    logic [OCC_W-1:0] best;

    // ascending scan with strict compare: ties keep the lower ID
    always_comb begin
        hit      = 1'b0;
        best     = '0;
        pick_tid = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (elig[i] && (!hit || occ_flat[i*OCC_W +: OCC_W] > best)) begin
                hit      = 1'b1;
                best     = occ_flat[i*OCC_W +: OCC_W];
                pick_tid = TID_W'(i);
            end
        end
    end

endmodule

// File: rtl/fetch_thread_sel.sv
`timescale 1ns/1ps
module fetch_thread_sel
    import fsel_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int OCC_W = 6,
    localparam int TID_W = $clog2(NTHR),
    localparam int CNT_W = $clog2(NTHR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               sel_policy,
    input  logic [CNT_W-1:0]         thr_count,
    input  logic                     hold,
    input  logic [NTHR*STAT_W-1:0]   thr_status,
    input  logic [NTHR*OCC_W-1:0]    iq_occ,
    input  logic [NTHR*OCC_W-1:0]    lsq_occ,
    output logic                     grant_vld,
    output logic [TID_W-1:0]         grant_tid,
    output logic                     cfg_err
);

    pol_e                  pol;
    sel_state_e            state_q, state_d;
    logic [NTHR-1:0]       elig;
    logic                  bad_cfg;
    logic                  solo;
    logic                  rr_adv, rr_hit, occ_hit;
    logic [TID_W-1:0]      rr_tid, occ_tid;
    logic [NTHR*OCC_W-1:0] occ_sel;

    assign pol     = pol_e'(sel_policy);
    assign bad_cfg = (pol == POL_SINGLE) && (thr_count > CNT_W'(1));
    assign solo    = (thr_count <= CNT_W'(1));
    assign occ_sel = (pol == POL_LSQ) ? lsq_occ : iq_occ;

    for (genvar gi = 0; gi < NTHR; gi++) begin : g_elig
        tstat_e st;
        assign st = tstat_e'(thr_status[gi*STAT_W +: STAT_W]);
        assign elig[gi] = ((st == TS_RUN) || (st == TS_DONE) || (st == TS_IDLE))
                          && (CNT_W'(gi) < thr_count);
    end

    fsel_rr_order #(.NTHR(NTHR), .TID_W(TID_W)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .adv      (rr_adv),
        .hit      (rr_hit),
        .pick_tid (rr_tid)
    );

    fsel_occ_pick #(.NTHR(NTHR), .TID_W(TID_W), .OCC_W(OCC_W)) u_occ (
        .elig     (elig),
        .occ_flat (occ_sel),
        .hit      (occ_hit),
        .pick_tid (occ_tid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERVE:   if (bad_cfg)  state_d = ST_CFG_ERR;   // SERVE_TO_ERR
            ST_CFG_ERR: if (!bad_cfg) state_d = ST_SERVE;     // ERR_TO_SERVE
            default:    state_d = ST_SERVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        grant_vld = 1'b0;
        grant_tid = '0;
        rr_adv    = 1'b0;
        cfg_err   = (state_q == ST_CFG_ERR);
        if (!hold && !bad_cfg) begin
            if (solo) begin
                grant_vld = elig[0];
            end else begin
                unique case (pol)
                    POL_SINGLE: grant_vld = 1'b0;
                    POL_RR: begin
                        grant_vld = rr_hit;
                        grant_tid = rr_tid;
                        rr_adv    = 1'b1;
                    end
                    POL_IQ, POL_LSQ: begin
                        grant_vld = occ_hit;
                        grant_tid = occ_tid;
                    end
                    default: grant_vld = 1'b0;
                endcase
            end
        end
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> thr_status[32'(grant_tid)*STAT_W +: STAT_W] <= 3'd2); // R1

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !grant_vld); // R10

    AST_ACTIVE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> CNT_W'(grant_tid) < thr_count); // R11

    AST_SINGLE_BAD_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_policy == 2'd0 && thr_count > CNT_W'(1)) |-> !grant_vld); // R6

    AST_SINGLE_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_policy == 2'd0 && thr_count > CNT_W'(1)) |=> cfg_err); // R6

    AST_SOLO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_count == CNT_W'(1) && grant_vld) |-> grant_tid == '0); // R7

endmodule

// File: tb/sim_fetch_thread_sel.sv
`timescale 1ns/1ps
module sim_fetch_thread_sel;

    localparam int NT = 4;
    localparam int OW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      pol = '0;
    logic [2:0]      cnt = 3'd4;
    logic            hold = 1'b1;
    logic [NT*3-1:0] st = '0;
    logic [NT*OW-1:0] iq = '0;
    logic [NT*OW-1:0] lsq = '0;
    logic            gv;
    logic [1:0]      gt;
    logic            ce;

    always #10 clk = ~clk;

    fetch_thread_sel u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_policy (pol),
        .thr_count  (cnt),
        .hold       (hold),
        .thr_status (st),
        .iq_occ     (iq),
        .lsq_occ    (lsq),
        .grant_vld  (gv),
        .grant_tid  (gt),
        .cfg_err    (ce)
    );

    typedef struct packed {
        logic       vld;
        logic [1:0] tid;
        logic       err;
    } exp_t;

    int    st_a[NT];
    int    iq_a[NT];
    int    lsq_a[NT];
    int    mlist[NT];
    bit    prev_bad;
    int    n_chk;
    int    n_fail;
    exp_t  exp_q[$];
    string tag_q[$];
    event  chk_ev;
    exp_t  mon_e;
    string mon_tag;

    task automatic set_st(input int a, input int b, input int c, input int d);
        st_a[0] = a; st_a[1] = b; st_a[2] = c; st_a[3] = d;
    endtask

    task automatic set_iq(input int a, input int b, input int c, input int d);
        iq_a[0] = a; iq_a[1] = b; iq_a[2] = c; iq_a[3] = d;
    endtask

    task automatic set_lsq(input int a, input int b, input int c, input int d);
        lsq_a[0] = a; lsq_a[1] = b; lsq_a[2] = c; lsq_a[3] = d;
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input int p, input int c, input bit h, input string tag);
        bit   el[NT];
        bit   bad;
        exp_t e;
        int   pos;
        int   best;
        int   occ;
        int   tmp;
        @(negedge clk);
        pol  = 2'(p);
        cnt  = 3'(c);
        hold = h;
        for (int i = 0; i < NT; i++) begin
            st[i*3 +: 3]   = 3'(st_a[i]);
            iq[i*OW +: OW]  = OW'(iq_a[i]);
            lsq[i*OW +: OW] = OW'(lsq_a[i]);
            el[i] = (st_a[i] <= 2) && (i < c);
        end
        bad = (p == 0) && (c > 1);
        e   = '0;
        if (!h && !bad) begin
            if (c <= 1) begin
                e.vld = el[0];
            end else if (p == 1) begin
                pos = -1;
                for (int k = 0; k < NT; k++)
                    if (pos < 0 && el[mlist[k]]) pos = k;
                if (pos >= 0) begin
                    e.vld = 1'b1;
                    e.tid = 2'(mlist[pos]);
                    tmp = mlist[pos];
                    for (int k = pos; k < NT - 1; k++) mlist[k] = mlist[k+1];
                    mlist[NT-1] = tmp;
                end
            end else begin
                best = -1;
                for (int i = 0; i < NT; i++) begin
                    occ = (p == 3) ? lsq_a[i] : iq_a[i];
                    if (el[i] && occ > best) begin
                        best  = occ;
                        e.vld = 1'b1;
                        e.tid = 2'(i);
                    end
                end
            end
        end
        e.err    = prev_bad;
        prev_bad = bad;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #2;
        ->chk_ev;
    endtask

    // monitor: pops the scoreboard and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            mon_e   = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            n_chk++;
            if (gv !== mon_e.vld || (mon_e.vld && gt !== mon_e.tid) || ce !== mon_e.err) begin
                n_fail++;
                $display("FAIL %s: actual vld=%0b tid=%0d err=%0b expected vld=%0b tid=%0d err=%0b",
                         mon_tag, gv, gt, ce, mon_e.vld, mon_e.tid, mon_e.err);
            end
        end
    end

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        prev_bad = 1'b0;
        for (int i = 0; i < NT; i++) mlist[i] = i;
        set_st(0, 0, 0, 0);
        set_iq(0, 0, 0, 0);
        set_lsq(0, 0, 0, 0);

        step(1, 4, 1'b1, "R4 in reset: no grant, cfg_err clear");
        @(negedge clk);
        rst_n = 1'b1;

        // R4 / R2: ascending start order, then rotation
        step(1, 4, 1'b0, "R4 head of reset list is thread 0");
        step(1, 4, 1'b0, "R2 rotation grants 1");
        step(1, 4, 1'b0, "R2 rotation grants 2");
        step(1, 4, 1'b0, "R2 rotation grants 3");
        step(1, 4, 1'b0, "R2 rotation wraps to 0");

        // R1: only codes 0,1,2 eligible
        set_st(3, 2, 4, 1);
        step(1, 4, 1'b0, "R1 skip blocked/squashing, pick idle or done");
        step(1, 4, 1'b0, "R1 next eligible from list");
        set_st(5, 6, 7, 1);
        step(1, 4, 1'b0, "R1 wait/off codes skipped");

        // R3 and R10: empty cycle and hold leave the list alone
        set_st(3, 4, 5, 7);
        step(1, 4, 1'b0, "R3 nothing eligible gives no grant");
        set_st(0, 0, 0, 0);
        step(1, 4, 1'b1, "R10 hold suppresses grant");
        step(1, 4, 1'b0, "R10 list unchanged after hold and empty cycle");
        step(1, 4, 1'b0, "R2 continue rotation");

        // R8: issue-queue count
        set_iq(5, 20, 20, 3);
        step(2, 4, 1'b0, "R8 highest iq count, tie to lower ID");
        set_st(0, 3, 0, 0);
        step(2, 4, 1'b0, "R8 blocked top thread skipped");
        set_st(3, 3, 3, 0);
        step(2, 4, 1'b0, "R1 only eligible thread wins despite lowest count");
        set_st(0, 0, 0, 0);
        step(1, 4, 1'b0, "R10 occupancy cycles did not rotate list");

        // R9: load/store-queue count, iq ignored
        set_lsq(40, 1, 63, 63);
        set_iq(63, 0, 0, 0);
        step(3, 4, 1'b0, "R9 highest lsq count, tie to lower ID");
        set_lsq(0, 9, 0, 0);
        step(3, 4, 1'b0, "R9 iq count ignored");

        // R11: inactive threads never granted
        set_iq(0, 1, 50, 60);
        step(2, 2, 1'b0, "R11 high-count inactive thread ignored");
        step(1, 2, 1'b0, "R11 round-robin within two threads");
        step(1, 2, 1'b0, "R11 round-robin within two threads again");
        step(1, 2, 1'b0, "R11 round-robin within two threads third");

        // R5: single-thread policy with one thread
        step(0, 1, 1'b0, "R5 single-thread grants thread 0");
        set_st(3, 0, 0, 0);
        step(0, 1, 1'b0, "R5 thread 0 blocked gives no grant");
        set_st(0, 0, 0, 0);

        // R7: one thread configured, every policy
        step(1, 1, 1'b0, "R7 round-robin with one thread grants 0");
        step(1, 1, 1'b0, "R7 repeated, list held");
        step(3, 1, 1'b0, "R7 lsq policy with one thread grants 0");
        step(1, 4, 1'b0, "R7 list unchanged after one-thread cycles");

        // R6: configuration error
        step(0, 4, 1'b0, "R6 bad config blocks grant at once");
        step(0, 4, 1'b0, "R6 cfg_err set next cycle");
        step(1, 4, 1'b0, "R6 cfg_err still set first corrected cycle");
        step(1, 4, 1'b0, "R6 cfg_err cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 scoreboard: actual=%0d leftover expected=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule